// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Receive FIFO

This block takes an idle-high asynchronous serial line and recovers characters from it. It is paced by a one-cycle tick that arrives sixteen times per bit period. The character format can be set to seven or eight data bits, with or without an even or odd parity bit, followed by one or two stop bits. Each completed frame is checked. Accepted characters go into a sixteen-entry receive FIFO. Each entry holds the character and a parity-error bit for that character.

The block keeps sticky status flags for frame errors, parity errors, overruns and line breaks. Software clears these flags with one-cycle strobes. Three interrupt lines drive the host: data ready, receive error and break. All three are gated by a single receive-interrupt enable. A programmable fill trigger raises a data-full flag once the FIFO holds enough characters. The host reads the character at the head of the FIFO from the data port and removes it with a read strobe. A receive error never stalls the receiver. The next start bit is detected as usual.

Top module: `uart_rx_fifo`

## Requirements
- R1: A low level on the idle line starts a frame. At the 8th tick after it is first seen, the line is sampled again. If it is high, the event is taken as a glitch, nothing is stored and no flag changes.
- R2: Data bits are sampled at mid-bit and assembled least significant bit first. With `cfg_seven`=1 there are seven data bits and `rdata[7]` reads 0. With `cfg_seven`=0 there are eight.
- R3: With `cfg_par_en`=1 a parity bit follows the data. The total count of ones is even when `cfg_par_odd`=0 and odd when it is 1. On a mismatch, the stored entry has `rperr`=1 and the sticky `perr_flag` is set.
- R4: Only the first stop bit is checked. A second stop bit (`cfg_two_stop`=1) is not checked. A low first stop bit sets the sticky `ferr` flag and the character is discarded.
- R5: A character is written to the FIFO only when its first stop bit is high, the FIFO is not full and the `brk` flag is clear.
- R6: After any receive error or break, the following well-formed frame is received normally.
- R7: The FIFO holds 16 entries and returns them in arrival order. `rd` removes the head entry, and `rd` while empty has no effect. `fill` gives the number of stored entries.
- R8: `dfull` is 1 exactly when `fill` >= `cfg_trig` (valid range 1 to 16).
- R9: If a frame with a valid stop bit completes while `fill` is 16, the sticky `ovr` flag is set, the character is discarded and `fill` stays 16.
- R10: A frame with every sample low up to and including the first stop bit sets both `brk` and `ferr`. `brk` stays set until a `brk_clr` pulse.
- R11: `dready` is 1 whenever `fill` is non-zero. `irq_rx` = `rie` AND (`dready` OR `dfull`).
- R12: `irq_err` = `rie` AND (`ferr` OR `perr_flag` OR `ovr`). `irq_brk` = `rie` AND `brk`. An `err_clr` pulse clears `ferr`, `perr_flag` and `ovr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits on the line |
| cfg_trig | input | 5 | FIFO fill level that raises dfull |
| rie | input | 1 | Enable for all three interrupt lines |
| rd | input | 1 | Pop the head FIFO entry |
| brk_clr | input | 1 | Clear the break flag |
| err_clr | input | 1 | Clear frame, parity and overrun flags |
| rdata | output | 8 | Character at the FIFO head |
| rperr | output | 1 | Parity-error bit of the head entry |
| fill | output | 5 | Number of stored entries |
| dready | output | 1 | FIFO not empty |
| dfull | output | 1 | Fill has reached the trigger level |
| ferr | output | 1 | Sticky frame error |
| perr_flag | output | 1 | Sticky parity error |
| ovr | output | 1 | Sticky overrun |
| brk | output | 1 | Sticky line break |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break interrupt |

## Verification
The properties assume that the format settings and `cfg_trig` change only while the line is idle, and that `cfg_trig` stays between 1 and 16. They also assume that `tick16` is a single-cycle pulse separated by idle cycles. Flag clears are treated as short pulses issued by software.

The stimulus respects all of these assumptions. It changes configuration only after a frame's stop bits plus an idle gap. It generates the tick from a fixed four-cycle cadence. It uses trigger values of 1 and 4. Line events are held in whole multiples of the bit period, except for the deliberate short low pulse that exercises glitch rejection.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rxd,
  input  logic                       tick16,
  input  logic                       cfg_seven,
  input  logic                       cfg_par_en,
  input  logic                       cfg_par_odd,
  input  logic                       cfg_two_stop,
  input  logic [$clog2(DEPTH):0]     cfg_trig,
  input  logic                       rie,
  input  logic                       rd,
  input  logic                       brk_clr,
  input  logic                       err_clr,
  output logic [7:0]                 rdata,
  output logic                       rperr,
  output logic [$clog2(DEPTH):0]     fill,
  output logic                       dready,
  output logic                       dfull,
  output logic                       ferr,
  output logic                       perr_flag,
  output logic                       ovr,
  output logic                       brk,
  output logic                       irq_rx,
  output logic                       irq_err,
  output logic                       irq_brk
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int SW  = $clog2(OSR);
  localparam logic [SW-1:0] MID  = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2, S_WAIT} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic [SW-1:0]    cnt;
  logic [2:0]       nbit;
  logic [7:0]       sr;
  logic             pbit, allz;
  logic [8:0]       mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  wire       rx       = sync[1];
  wire       samp     = tick16 && (cnt == LAST);
  wire       last_bit = nbit == (cfg_seven ? 3'd6 : 3'd7);
  wire [7:0] word     = cfg_seven ? {1'b0, sr[7:1]} : sr;
  wire       par_bad  = cfg_par_en && (pbit != (^word ^ cfg_par_odd));
  wire       done     = samp && (st == S_STOP);
  wire       full     = fill == CW'(DEPTH);
  wire       brk_now  = done && allz && !rx;
  wire       push     = done && rx && !full && !brk;
  wire       pop      = rd && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sr   <= '0;
      pbit <= 1'b0;
      allz <= 1'b0;
    end else if (tick16) begin
      if (st != S_IDLE && st != S_START && st != S_WAIT)
        cnt <= samp ? '0 : cnt + SW'(1);
      case (st)
        S_IDLE:  if (!rx) begin st <= S_START; cnt <= '0; end
        S_START: begin
          if (cnt == MID) begin
            cnt <= '0;
            if (rx) st <= S_IDLE;
            else begin st <= S_DATA; nbit <= '0; allz <= 1'b1; end
          end else cnt <= cnt + SW'(1);
        end
        S_DATA: if (samp) begin
          sr   <= {rx, sr[7:1]};
          allz <= allz & ~rx;
          nbit <= nbit + 3'd1;
          if (last_bit) st <= cfg_par_en ? S_PAR : S_STOP;
        end
        S_PAR: if (samp) begin
          pbit <= rx;
          allz <= allz & ~rx;
          st   <= S_STOP;
        end
        S_STOP:  if (samp) st <= !rx ? S_WAIT : (cfg_two_stop ? S_STOP2 : S_IDLE);
        S_STOP2: if (samp) st <= S_WAIT;
        S_WAIT:  if (rx) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {par_bad, word};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ferr      <= 1'b0;
      perr_flag <= 1'b0;
      ovr       <= 1'b0;
      brk       <= 1'b0;
    end else begin
      if (done && !rx)            ferr <= 1'b1;
      else if (err_clr)           ferr <= 1'b0;
      if (push && par_bad)        perr_flag <= 1'b1;
      else if (err_clr)           perr_flag <= 1'b0;
      if (done && rx && full)     ovr <= 1'b1;
      else if (err_clr)           ovr <= 1'b0;
      if (brk_now)                brk <= 1'b1;
      else if (brk_clr)           brk <= 1'b0;
    end
  end

  assign rdata   = mem[rp][7:0];
  assign rperr   = mem[rp][8];
  assign dready  = fill != '0;
  assign dfull   = fill >= cfg_trig;
  assign irq_rx  = rie && (dready || dfull);
  assign irq_err = rie && (ferr || perr_flag || ovr);
  assign irq_brk = rie && brk;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rie,
  input logic [CW-1:0] fill,
  input logic          dready,
  input logic          ferr,
  input logic          err_clr,
  input logic          ovr,
  input logic          brk,
  input logic          brk_clr,
  input logic          irq_rx,
  input logic          irq_err,
  input logic          irq_brk
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH)); // R7
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + CW'(1)) || (fill == $past(fill) - CW'(1))); // R7
  AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(fill) == CW'(DEPTH)); // R9
  AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) brk && !brk_clr |=> brk); // R10
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ferr && !err_clr |=> ferr); // R12
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (!rst_n) rie && dready |-> irq_rx); // R11
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> !(irq_rx || irq_err || irq_brk)); // R12
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rie(rie), .fill(fill), .dready(dready),
  .ferr(ferr), .err_clr(err_clr), .ovr(ovr), .brk(brk), .brk_clr(brk_clr),
  .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk)
);

// File: tb/sim_uart_rx_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo;
  localparam int DEPTH = 16;
  localparam int BITC  = 64;

  logic clk = 0, rst_n = 0, rxd = 1, tick16 = 0;
  logic cfg_seven = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic [4:0] cfg_trig = 5'd1;
  logic rie = 1, rd = 0, brk_clr = 0, err_clr = 0;
  logic [7:0] rdata;
  logic [4:0] fill;
  logic rperr, dready, dfull, ferr, perr_flag, ovr, brk, irq_rx, irq_err, irq_brk;

  uart_rx_fifo u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, mcount = 0;
  bit mferr = 0, mperr = 0, movr = 0, mbrk = 0, drain = 1;
  logic [8:0] expq [$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1;
      @(negedge clk);
      tick16 = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // monitor: pops the scoreboard as the design presents entries
  initial begin
    forever begin
      @(negedge clk);
      if (drain && dready) begin
        checks++;
        if (expq.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected entry actual=%0h expected=none", {rperr, rdata});
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          if ({rperr, rdata} != e) begin
            fails++;
            $display("FAIL R2/R3/R7 head actual=%0h expected=%0h", {rperr, rdata}, e);
          end
        end
        mcount--;
        rd = 1;
      end else rd = 0;
    end
  end

  task automatic line_bit(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input logic s1, input logic s2);
    logic [7:0] w;
    logic pb, acc, pe;
    w  = cfg_seven ? {1'b0, d[6:0]} : d;
    pb = (^w) ^ cfg_par_odd ^ bad_par;
    pe = cfg_par_en && bad_par;
    line_bit(1'b0);
    for (int i = 0; i < (cfg_seven ? 7 : 8); i++) line_bit(w[i]);
    if (cfg_par_en) line_bit(pb);
    acc = s1 && (mcount < DEPTH) && !mbrk;
    if (acc) begin expq.push_back({pe, w}); mcount++; mperr |= pe; end
    if (!s1) mferr = 1;
    if (s1 && mcount >= DEPTH && !acc && !mbrk) movr = 1;
    line_bit(s1);
    if (cfg_two_stop) line_bit(s2);
    rxd = 1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic flags(input string tag);
    chk({tag, " ferr"}, ferr, mferr);
    chk({tag, " perr_flag"}, perr_flag, mperr);
    chk({tag, " ovr"}, ovr, movr);
    chk({tag, " brk"}, brk, mbrk);
  endtask

  task automatic pulse_err_clr;
    err_clr = 1; @(negedge clk); err_clr = 0;
    mferr = 0; mperr = 0; movr = 0;
  endtask

  initial begin
    repeat (10) @(negedge clk);
    chk("R7 reset fill", fill, 0);
    chk("R11 reset dready", dready, 0);
    chk("R11 reset irq_rx", irq_rx, 0);
    chk("R12 reset irq_err", irq_err, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    flags("R12 reset");

    // R2: 8 data bits, no parity
    send(8'h55, 0, 1, 1); send(8'hA3, 0, 1, 1); send(8'h00, 0, 1, 1);
    send(8'hFF, 0, 1, 1); send(8'h81, 0, 1, 1);
    chk("R7 drained fill", fill, 0);
    flags("R2 clean");

    // R3: 7 bits even parity, then odd parity on 8 bits
    cfg_seven = 1; cfg_par_en = 1; cfg_par_odd = 0;
    send(8'h35, 0, 1, 1); send(8'hFF, 0, 1, 1); send(8'h12, 1, 1, 1);
    flags("R3 even");
    chk("R12 irq_err parity", irq_err, 1);
    pulse_err_clr();
    flags("R12 after clear");
    cfg_seven = 0; cfg_par_odd = 1;
    send(8'hC4, 0, 1, 1); send(8'h0F, 1, 1, 1);
    flags("R3 odd");
    pulse_err_clr();

    // R4: second stop unchecked, first stop checked; R6 recovery
    cfg_par_en = 0; cfg_two_stop = 1;
    send(8'h5A, 0, 1, 0);
    flags("R4 second stop low");
    send(8'h3C, 0, 0, 1);
    flags("R4 first stop low");
    chk("R4 discarded fill", fill, 0);
    send(8'h96, 0, 1, 1);
    flags("R6 after frame error");
    pulse_err_clr();
    cfg_two_stop = 0;

    // R1: short low pulse rejected
    rxd = 0; repeat (12) @(negedge clk); rxd = 1;
    repeat (3 * BITC) @(negedge clk);
    chk("R1 glitch fill", fill, 0);
    flags("R1 glitch");
    send(8'h66, 0, 1, 1);

    // R8, R9, R11: fill without draining
    drain = 0; cfg_trig = 5'd4;
    for (int i = 0; i < 3; i++) send(8'(8'h10 + i), 0, 1, 1);
    chk("R8 dfull below trig", dfull, 0);
    chk("R11 dready", dready, 1);
    chk("R11 irq_rx", irq_rx, 1);
    send(8'h13, 0, 1, 1);
    chk("R8 dfull at trig", dfull, 1);
    rie = 0; @(negedge clk);
    chk("R11 irq_rx gated", irq_rx, 0);
    rie = 1;
    for (int i = 4; i < 16; i++) send(8'(8'h10 + i), 0, 1, 1);
    chk("R7 fill full", fill, 16);
    send(8'hEE, 0, 1, 1);
    chk("R9 fill stays", fill, 16);
    flags("R9 overrun");
    chk("R12 irq_err overrun", irq_err, 1);
    drain = 1;
    repeat (40) @(negedge clk);
    drain = 0;
    chk("R7 drained all", fill, 0);
    chk("R7 queue empty", expq.size(), 0);
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
    chk("R7 read empty", fill, 0);
    drain = 1;
    pulse_err_clr();
    cfg_trig = 5'd1;

    // R10, R5: break and gating of storage
    line_bit(1'b0);
    repeat (11) line_bit(1'b0);
    mbrk = 1; mferr = 1;
    rxd = 1; repeat (BITC) @(negedge clk);
    flags("R10 break");
    chk("R12 irq_brk", irq_brk, 1);
    rie = 0; @(negedge clk);
    chk("R12 irq_brk gated", irq_brk, 0);
    chk("R12 irq_err gated", irq_err, 0);
    rie = 1;
    send(8'h44, 0, 1, 1);
    chk("R5 blocked by break", fill, 0);
    flags("R10 sticky");
    brk_clr = 1; @(negedge clk); brk_clr = 0; mbrk = 0;
    chk("R10 cleared", brk, 0);
    pulse_err_clr();
    send(8'h44, 0, 1, 1);
    flags("R6 after break");
    chk("R5 queue empty", expq.size(), 0);

    summary();
    $finish;
  end
endmodule